// File: doc/BRIEF.md
# Serial Configuration Port with Register Bank

This block is the control-side slave of a line-card voice channel. A host reaches it through a four-wire serial link: a serial clock, an active-low chip select, a data input and a data output with an output enable. Each instruction begins with a command byte. That byte carries a power-state bit, a four-bit register address, a read/write flag and a length flag. A two-byte write stores the following byte into one of ten 8-bit configuration registers. A two-byte read shifts the selected register back to the host. A one-byte command only sets the power state.

All serial inputs pass through two-flop synchronisers into the system clock domain, where the serial clock edges are detected. The system clock must be at least four times faster than the serial clock. Input bits are taken on serial falling edges and read data is launched on serial rising edges. Raising chip select part-way through a byte abandons the instruction with no side effects. A gap in chip select between the two bytes of an instruction is allowed.

Top module: `ser_cfg_port`

## Requirements
- R1: After reset all ten configuration outputs are zero, `pwr_down` is 1 and `sdo_oe` is 0.
- R2: Bytes travel MSB first and bits are taken on serial falling edges. In the command byte, bit 7 is the power bit, bits 6..3 are the address, bit 2 is read (1) / write (0) and bit 1 is the length flag (1 = a second byte follows). Bit 0 is ignored. For a two-byte write, the second byte is stored at the end of its eighth bit.
- R3: The address codes map to outputs as follows: 0 `cfg_ctrl`, 1 `cfg_latch`, 2 `cfg_dir`, 4 `cfg_rxgain`, 5 `cfg_txgain`, 6/7/8 `cfg_bal1`/`cfg_bal2`/`cfg_bal3`, 9 `cfg_rxslot`, 10 `cfg_txslot`.
- R4: A two-byte read drives the addressed register on `sdo` during the second byte. The data is MSB first and each bit is launched on a serial rising edge.
- R5: A command byte with length flag 0 changes no register. The byte that follows it is decoded as a new command byte.
- R6: The power bit (1 = powered down) of each completed instruction sets `pwr_down`. For a one-byte command this happens at the end of the byte. For a two-byte instruction it happens at the end of the second byte, not the first.
- R7: If chip select rises after 1 to 7 bits of either byte, no register and no power state change. The next bit clocked in starts a new command byte.
- R8: The second byte may follow in the same chip-select window or in a later one. Several instructions may share one window.
- R9: A write to an unused address (3, 11 to 15) changes no register. A read of an unused address returns all zeros.
- R10: `sdo_oe` is 0 while chip select is high and outside the data byte of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the `sdo` pad driver |
| pwr_down | output | 1 | Power state, 1 = powered down |
| cfg_ctrl | output | 8 | Control register |
| cfg_latch | output | 8 | Interface latch data |
| cfg_dir | output | 8 | Latch direction |
| cfg_rxgain | output | 8 | Receive gain |
| cfg_txgain | output | 8 | Transmit gain |
| cfg_bal1 | output | 8 | Balance coefficient 1 |
| cfg_bal2 | output | 8 | Balance coefficient 2 |
| cfg_bal3 | output | 8 | Balance coefficient 3 |
| cfg_rxslot | output | 8 | Receive time-slot and port |
| cfg_txslot | output | 8 | Transmit time-slot and port |

## Verification
A serial edge reaches the decode logic two system clocks after the pin changes. Register, power-state and `sdo` updates land on the third system clock. The bench holds each serial half-period for six system clocks and reads `sdo` five clocks after each rising edge, which is after the launch and before the next falling edge. Registers and `pwr_down` are checked only after chip select has risen and the synchronisers have settled. In the split-window cases, `pwr_down` is checked between the two bytes, so that an early update would be seen.

// File: rtl/ser_cfg_port.sv
module ser_cfg_port #(
  parameter int DW   = 8,
  parameter int AW   = 4,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          sdi,
  output logic          sdo,
  output logic          sdo_oe,
  output logic          pwr_down,
  output logic [DW-1:0] cfg_ctrl,
  output logic [DW-1:0] cfg_latch,
  output logic [DW-1:0] cfg_dir,
  output logic [DW-1:0] cfg_rxgain,
  output logic [DW-1:0] cfg_txgain,
  output logic [DW-1:0] cfg_bal1,
  output logic [DW-1:0] cfg_bal2,
  output logic [DW-1:0] cfg_bal3,
  output logic [DW-1:0] cfg_rxslot,
  output logic [DW-1:0] cfg_txslot
);
  localparam int NR    = 1 << AW;
  localparam int BW    = $clog2(DW);
  localparam int B_PWR = DW - 1;
  localparam int B_AD  = DW - 2;
  localparam int B_RD  = 2;
  localparam int B_LEN = 1;
  localparam logic [NR-1:0] VALID = NR'(16'h07F7);

  logic [SYNC:0]   sclk_p;
  logic [SYNC-1:0] cs_p, sdi_p;
  logic [BW-1:0]   bitcnt;
  logic [DW-1:0]   sh, hdr, obuf;
  logic            second, sdo_r;
  logic [DW-1:0]   regs [NR];

  wire cs_s  = cs_p[SYNC-1];
  wire sdi_s = sdi_p[SYNC-1];
  wire fall  = sclk_p[SYNC] & ~sclk_p[SYNC-1] & ~cs_s;
  wire rise  = ~sclk_p[SYNC] & sclk_p[SYNC-1] & ~cs_s;

  wire [DW-1:0] sh_nx     = {sh[DW-2:0], sdi_s};
  wire          byte_done = fall && (bitcnt == BW'(DW - 1));
  wire [AW-1:0] n_addr    = sh_nx[B_AD -: AW];
  wire [AW-1:0] h_addr    = hdr[B_AD -: AW];
  wire          rd_phase  = second & hdr[B_RD];
  wire          commit    = byte_done & second & ~hdr[B_RD] & VALID[h_addr];
  wire          fin       = byte_done & (second | ~sh_nx[B_LEN]);
  wire [DW-1:0] rd_val    = VALID[n_addr] ? regs[n_addr] : '0;

  assign sdo    = sdo_r;
  assign sdo_oe = ~cs_s & rd_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p   <= '0;
      cs_p     <= '1;
      sdi_p    <= '0;
      bitcnt   <= '0;
      sh       <= '0;
      hdr      <= '0;
      obuf     <= '0;
      second   <= 1'b0;
      sdo_r    <= 1'b0;
      pwr_down <= 1'b1;
      for (int i = 0; i < NR; i++) regs[i] <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC-1:0], sclk};
      cs_p   <= {cs_p[SYNC-2:0], cs_n};
      sdi_p  <= {sdi_p[SYNC-2:0], sdi};
      if (cs_s) begin
        if (bitcnt != '0) second <= 1'b0;
        bitcnt <= '0;
      end else if (fall) begin
        bitcnt <= BW'(bitcnt + 1'b1);
        sh     <= sh_nx;
        if (byte_done) begin
          if (second) second <= 1'b0;
          else if (sh_nx[B_LEN]) begin
            second <= 1'b1;
            hdr    <= sh_nx;
            obuf   <= rd_val;
          end
        end
      end
      if (rise && rd_phase) begin
        sdo_r <= obuf[DW-1];
        obuf  <= {obuf[DW-2:0], 1'b0};
      end
      if (fin) pwr_down <= second ? hdr[B_PWR] : sh_nx[B_PWR];
      if (commit) regs[h_addr] <= sh_nx;
    end
  end

  assign cfg_ctrl   = regs[0];
  assign cfg_latch  = regs[1];
  assign cfg_dir    = regs[2];
  assign cfg_rxgain = regs[4];
  assign cfg_txgain = regs[5];
  assign cfg_bal1   = regs[6];
  assign cfg_bal2   = regs[7];
  assign cfg_bal3   = regs[8];
  assign cfg_rxslot = regs[9];
  assign cfg_txslot = regs[10];

  wire [10*DW-1:0] bank = {cfg_ctrl, cfg_latch, cfg_dir, cfg_rxgain, cfg_txgain,
                           cfg_bal1, cfg_bal2, cfg_bal3, cfg_rxslot, cfg_txslot};

  p_bank_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(bank));

  p_pwr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(pwr_down));

  p_abort_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && bitcnt != '0) |=> (!second && bitcnt == '0));

  p_bit_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> bitcnt == BW'($past(bitcnt) + 1'b1));

  p_oe_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !sdo_oe);
endmodule

// File: tb/ser_cfg_port_tb.sv
module ser_cfg_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, pwr_down;
  logic [7:0] c_ctrl, c_latch, c_dir, c_rxg, c_txg, c_b1, c_b2, c_b3, c_rxs, c_txs;
  int checks = 0, fails = 0;
  logic [7:0] mdl [16];
  logic oe_seen;

  always #4 clk = ~clk;

  ser_cfg_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .pwr_down(pwr_down),
    .cfg_ctrl(c_ctrl), .cfg_latch(c_latch), .cfg_dir(c_dir),
    .cfg_rxgain(c_rxg), .cfg_txgain(c_txg), .cfg_bal1(c_b1),
    .cfg_bal2(c_b2), .cfg_bal3(c_b3), .cfg_rxslot(c_rxs), .cfg_txslot(c_txs));

  localparam logic [11:0] VEC [10] = '{
    {4'd0, 8'h5A}, {4'd1, 8'hC3}, {4'd2, 8'h81}, {4'd4, 8'h7E}, {4'd5, 8'h12},
    {4'd6, 8'hA5}, {4'd7, 8'h3C}, {4'd8, 8'hF0}, {4'd9, 8'h0F}, {4'd10, 8'h96}};

  function automatic logic [7:0] port_val(input logic [3:0] a);
    case (a)
      4'd0: return c_ctrl;   4'd1: return c_latch; 4'd2: return c_dir;
      4'd4: return c_rxg;    4'd5: return c_txg;   4'd6: return c_b1;
      4'd7: return c_b2;     4'd8: return c_b3;    4'd9: return c_rxs;
      4'd10: return c_txs;   default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] cmd(input logic p, input logic [3:0] a,
                                     input logic rd, input logic two);
    return {p, a, rd, two, 1'b0};
  endfunction

  task automatic wt(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] b, input int nb, output logic [7:0] r);
    r = 8'h00;
    for (int i = 0; i < nb; i++) begin
      sdi = b[7-i];
      sclk = 1'b1;
      wt(5);
      r[7-i] = sdo;
      oe_seen |= sdo_oe;
      wt(1);
      sclk = 1'b0;
      wt(6);
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wt(3);
  endtask

  task automatic cs_hi();
    wt(3);
    cs_n = 1'b1;
    wt(8);
  endtask

  task automatic wr(input logic p, input logic [3:0] a, input logic [7:0] d);
    logic [7:0] r;
    cs_lo();
    xfer(cmd(p, a, 1'b0, 1'b1), 8, r);
    xfer(d, 8, r);
    cs_hi();
  endtask

  task automatic rd(input logic p, input logic [3:0] a, output logic [7:0] d);
    logic [7:0] r;
    cs_lo();
    xfer(cmd(p, a, 1'b1, 1'b1), 8, r);
    xfer(8'h00, 8, d);
    cs_hi();
  endtask

  task automatic chk_bank(input string tag);
    for (int a = 0; a < 11; a++) chk(tag, port_val(4'(a)), mdl[a]);
  endtask

  bit done = 0;
  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, d;
    for (int i = 0; i < 16; i++) mdl[i] = 8'h00;
    wt(4);
    rst_n = 1'b1;
    wt(4);
    // R1 reset state
    chk("R1 pwr_down", {7'd0, pwr_down}, 8'h01);
    chk("R1 sdo_oe", {7'd0, sdo_oe}, 8'h00);
    chk_bank("R1 register zero");

    // R5 R6 single-byte power up
    cs_lo(); xfer(cmd(1'b0, 4'd0, 1'b0, 1'b0), 8, r); cs_hi();
    chk("R6 single-byte power up", {7'd0, pwr_down}, 8'h00);
    chk("R5 single byte leaves ctrl", c_ctrl, 8'h00);

    // R2 R3 R4 vector table: write then read back
    for (int v = 0; v < 10; v++) begin
      logic [3:0] a;
      logic [7:0] dv;
      a = VEC[v][11:8];
      dv = VEC[v][7:0];
      wr(1'b0, a, dv);
      mdl[a] = dv;
      chk("R3 R2 write to mapped port", port_val(a), dv);
      oe_seen = 1'b0;
      rd(1'b0, a, d);
      chk("R4 read back on sdo", d, dv);
      chk("R10 oe on during read data", {7'd0, oe_seen}, 8'h01);
    end
    chk_bank("R3 bank after table");
    chk("R10 oe off with cs high", {7'd0, sdo_oe}, 8'h00);

    // R5: length 0 byte followed by data byte in same window
    cs_lo();
    xfer(cmd(1'b0, 4'd1, 1'b0, 1'b0), 8, r);
    xfer(8'h00, 8, r);
    cs_hi();
    chk("R5 latch unchanged", c_latch, mdl[1]);
    chk("R5 pwr still up", {7'd0, pwr_down}, 8'h00);

    // R6 R8: split windows, power applied only at end of second byte
    cs_lo(); xfer(cmd(1'b1, 4'd0, 1'b0, 1'b1), 8, r); cs_hi();
    chk("R6 pwr not applied after first byte", {7'd0, pwr_down}, 8'h00);
    chk("R8 ctrl untouched between windows", c_ctrl, mdl[0]);
    cs_lo(); xfer(8'h33, 8, r); cs_hi();
    mdl[0] = 8'h33;
    chk("R8 split-window write", c_ctrl, 8'h33);
    chk("R6 pwr from two-byte write", {7'd0, pwr_down}, 8'h01);

    // R7 abort during first byte
    cs_lo(); xfer(cmd(1'b0, 4'd9, 1'b0, 1'b1), 5, r); cs_hi();
    chk("R7 pwr after byte1 abort", {7'd0, pwr_down}, 8'h01);
    wr(1'b1, 4'd9, 8'h77);
    mdl[9] = 8'h77;
    chk("R7 fresh start after byte1 abort", c_rxs, 8'h77);

    // R7 abort during second byte
    cs_lo();
    xfer(cmd(1'b0, 4'd5, 1'b0, 1'b1), 8, r);
    xfer(8'hC3, 4, r);
    cs_hi();
    chk("R7 txgain after byte2 abort", c_txg, mdl[5]);
    chk("R7 pwr after byte2 abort", {7'd0, pwr_down}, 8'h01);
    wr(1'b0, 4'd10, 8'h99);
    mdl[10] = 8'h99;
    chk("R7 next write decodes as command", c_txs, 8'h99);
    chk("R7 txgain still held", c_txg, mdl[5]);
    chk("R6 pwr up after write", {7'd0, pwr_down}, 8'h00);

    // R8 back to back in one window
    cs_lo();
    xfer(cmd(1'b0, 4'd1, 1'b0, 1'b1), 8, r); xfer(8'h11, 8, r);
    xfer(cmd(1'b0, 4'd2, 1'b0, 1'b1), 8, r); xfer(8'h22, 8, r);
    xfer(cmd(1'b0, 4'd1, 1'b1, 1'b1), 8, r); xfer(8'h00, 8, d);
    cs_hi();
    mdl[1] = 8'h11; mdl[2] = 8'h22;
    chk("R8 back-to-back write 1", c_latch, 8'h11);
    chk("R8 back-to-back write 2", c_dir, 8'h22);
    chk("R8 back-to-back read", d, 8'h11);

    // R9 invalid addresses
    wr(1'b0, 4'd3, 8'hEE);
    wr(1'b0, 4'd15, 8'hEE);
    chk_bank("R9 invalid write ignored");
    rd(1'b0, 4'd3, d);
    chk("R9 invalid read zero (3)", d, 8'h00);
    rd(1'b0, 4'd12, d);
    chk("R9 invalid read zero (12)", d, 8'h00);
    wr(1'b1, 4'd11, 8'h55);
    chk("R9 invalid write still sets power", {7'd0, pwr_down}, 8'h01);

    // R10 oe off during a write data byte
    oe_seen = 1'b0;
    wr(1'b1, 4'd4, 8'h44);
    mdl[4] = 8'h44;
    chk("R10 oe off during write", {7'd0, oe_seen}, 8'h00);
    chk("R2 final write", c_rxg, 8'h44);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule